// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block supervises a battery-backed static memory. It watches two digital flags from external supply comparators. One flag says the supply is above the deselect threshold. The other says the supply is above the battery switchover threshold. From these flags it drives two signals. The first write-protects and deselects the memory. The second selects the internal battery as the power source.

When the supply fails while a memory cycle is in progress, the sequencer lets that cycle finish. It waits only up to a bounded grace window, and after that it forces protection. When the supply returns, protection is held for a long recovery interval before normal accesses are allowed again. A dip in the supply during that interval restarts the interval.

Both flags pass through a two-flop synchronizer. All timing comes from a free-running clock. The grace window and the recovery interval are set by parameters given in clock cycles.

Top module: `pfws_top`

## Requirements
- R1: While reset is asserted, `protect` is 1 and `batterySel` is 0. After reset is released with both raw flags high, `protect` stays 1 and first reads 0 after exactly 3 + RECOVER_CYCLES rising clock edges.
- R2: In normal operation with `accessActive` low, a fall of `supplyOkRaw` sets `protect` to 1 at the third rising edge after the change.
- R3: In normal operation with `accessActive` high, a fall of `supplyOkRaw` leaves `protect` at 0 through edge 2 + GRACE_CYCLES after the change. Protection is then forced at edge 3 + GRACE_CYCLES, even if `accessActive` is still high.
- R4: While an access is being allowed to finish, a fall of `accessActive` sets `protect` to 1 at the next rising edge.
- R5: A fall of `switchOkRaw` sets both `batterySel` and `protect` to 1 at the third rising edge after the change. This holds from any state, including an access that is being allowed to finish.
- R6: A rise of `switchOkRaw` clears `batterySel` at the third rising edge after the change. `protect` stays 1 at that point.
- R7: Once both synchronized flags are high in the protected state, `protect` first reads 0 after 3 + RECOVER_CYCLES edges counted from the raw change.
- R8: A fall of `supplyOkRaw` during recovery returns the block to the protected state. The next recovery then counts its full length again from zero.
- R9: Inconsistent flags never release protection. With `switchOkRaw` high and `supplyOkRaw` low, the block is protected with `batterySel` at 0. With `supplyOkRaw` high and `switchOkRaw` low, it is protected with `batterySel` at 1.
- R10: `accessActive` has no effect on either output while the block is protected. It also has no effect in normal operation while the supply is good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock for the synchronizer and the timers |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOkRaw | input | 1 | Asynchronous comparator flag: supply above the deselect threshold |
| switchOkRaw | input | 1 | Asynchronous comparator flag: supply above the battery switchover threshold |
| accessActive | input | 1 | High while a memory cycle is in progress; synchronous to clk |
| protect | output | 1 | 1 = memory write-protected and deselected |
| batterySel | output | 1 | 1 = internal battery powers the memory |

## Verification
The assertions rely on two assumptions about the inputs:
- `accessActive` is synchronous to the clock.
- The raw flags are held long enough to cross the two synchronizer stages.

With these in place, every state change follows the synchronized flags within one cycle. The stimulus changes every input only on falling clock edges. Each value is held for at least one full cycle, and usually for at least three, so that a flag change always reaches the state machine before the next change.

// File: rtl/pfws_pkg.sv
package pfws_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL,
    ST_PENDING,
    ST_PROTECT,
    ST_BACKUP,
    ST_RECOVER
  } seqState_t;

  typedef struct packed {
    logic clr;
    logic inc;
  } timerCmd_t;

endpackage

// File: rtl/pfws_sync.sv
module pfws_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[s] <= RESET_VAL;
        else       pipe[s] <= rawIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[s] <= RESET_VAL;
        else       pipe[s] <= pipe[s-1];
      end
    end
  end

  assign syncOut = pipe[STAGES-1];

endmodule

// File: rtl/pfws_timer.sv
module pfws_timer
  import pfws_pkg::*;
#(
  parameter int GRACE_CYCLES = 1000,
  parameter int RECOVER_CYCLES = 4000000
) (
  input  logic      clk,
  input  logic      rstN,
  input  timerCmd_t cmd,
  output logic      graceHit,
  output logic      recoverHit
);

  localparam int MAX_LEN = (GRACE_CYCLES > RECOVER_CYCLES) ? GRACE_CYCLES : RECOVER_CYCLES;
  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] GRACE_LAST = CNT_W'(GRACE_CYCLES - 1);
  localparam logic [CNT_W-1:0] RECOVER_LAST = CNT_W'(RECOVER_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (cmd.clr) cnt <= '0;
    else if (cmd.inc) cnt <= cnt + 1'b1;
  end

  assign graceHit = (cnt == GRACE_LAST);
  assign recoverHit = (cnt == RECOVER_LAST);

  // R8
  timer_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clr |=> cnt == '0);

  // R7
  timer_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.inc && !cmd.clr) |=> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/pfws_ctrl.sv
module pfws_ctrl
  import pfws_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      supOk,
  input  logic      swOk,
  input  logic      accessActive,
  input  logic      graceHit,
  input  logic      recoverHit,
  output timerCmd_t cmd,
  output logic      protect,
  output logic      batterySel
);

  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_NORMAL: begin
        if (!swOk)       nextState = ST_BACKUP;
        else if (!supOk) nextState = accessActive ? ST_PENDING : ST_PROTECT;
      end
      ST_PENDING: begin
        if (!swOk)                         nextState = ST_BACKUP;
        else if (!accessActive || graceHit) nextState = ST_PROTECT;
      end
      ST_PROTECT: begin
        if (!swOk)      nextState = ST_BACKUP;
        else if (supOk) nextState = ST_RECOVER;
      end
      ST_BACKUP: begin
        if (swOk) nextState = supOk ? ST_RECOVER : ST_PROTECT;
      end
      ST_RECOVER: begin
        if (!swOk)           nextState = ST_BACKUP;
        else if (!supOk)     nextState = ST_PROTECT;
        else if (recoverHit) nextState = ST_NORMAL;
      end
      default: nextState = ST_PROTECT;
    endcase
  end

  always_comb begin
    cmd.clr = (nextState != state);
    cmd.inc = (state == ST_PENDING) || (state == ST_RECOVER);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_PROTECT;
      protect    <= 1'b1;
      batterySel <= 1'b0;
    end else begin
      state      <= nextState;
      protect    <= !((nextState == ST_NORMAL) || (nextState == ST_PENDING));
      batterySel <= (nextState == ST_BACKUP);
    end
  end

  // R2
  leave_normal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NORMAL && !supOk) |=> state != ST_NORMAL);

  // R3
  grace_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PENDING && graceHit) |=> protect);

  // R5
  battery_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    !swOk |=> batterySel);

  // R5
  battery_protect_chk: assert property (@(posedge clk) disable iff (!rstN)
    batterySel |-> protect);

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(protect) |-> ($past(state) == ST_RECOVER && $past(recoverHit)));

endmodule

// File: rtl/pfws_top.sv
module pfws_top
  import pfws_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GRACE_CYCLES = 1000,
  parameter int RECOVER_CYCLES = 4000000
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOkRaw,
  input  logic switchOkRaw,
  input  logic accessActive,
  output logic protect,
  output logic batterySel
);

  logic [1:0] flagsSync;
  logic       graceHit, recoverHit;
  timerCmd_t  cmd;

  // bit 1: switchover flag resets high (external supply assumed), bit 0: deselect flag resets low
  pfws_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RESET_VAL(2'b10)) u_sync (
    .clk(clk), .rstN(rstN),
    .rawIn({switchOkRaw, supplyOkRaw}),
    .syncOut(flagsSync)
  );

  pfws_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .supOk(flagsSync[0]), .swOk(flagsSync[1]),
    .accessActive(accessActive),
    .graceHit(graceHit), .recoverHit(recoverHit),
    .cmd(cmd), .protect(protect), .batterySel(batterySel)
  );

  pfws_timer #(.GRACE_CYCLES(GRACE_CYCLES), .RECOVER_CYCLES(RECOVER_CYCLES)) u_timer (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .graceHit(graceHit), .recoverHit(recoverHit)
  );

endmodule

// File: tb/pfws_top_tb.sv
module pfws_top_tb;

  localparam int G = 6;
  localparam int R = 10;
  localparam int NVEC = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supRaw = 1'b1, swRaw = 1'b1, acc = 1'b0;
  logic protect, batterySel;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pfws_top #(.SYNC_STAGES(2), .GRACE_CYCLES(G), .RECOVER_CYCLES(R)) u_dut (
    .clk(clk), .rstN(rstN), .supplyOkRaw(supRaw), .switchOkRaw(swRaw),
    .accessActive(acc), .protect(protect), .batterySel(batterySel)
  );

  // fields: sup, sw, acc, ticks[6:0], expProtect, expBattery
  localparam logic [11:0] VEC [NVEC] = '{
    {3'b111, 7'd4,      2'b00},  // R10 access with good supply
    {3'b010, 7'd3,      2'b10},  // R2 drop, no access
    {3'b000, 7'd3,      2'b11},  // R5 switchover lost
    {3'b100, 7'd3,      2'b11},  // R9 deselect ok, switch low
    {3'b011, 7'd3,      2'b10},  // R6 / R9 switch back, deselect low
    {3'b110, 7'(2 + R), 2'b10},  // R7 still recovering
    {3'b110, 7'd1,      2'b00},  // R7 released
    {3'b011, 7'd3,      2'b00},  // R3 access allowed to finish
    {3'b010, 7'd1,      2'b10},  // R4 access ended
    {3'b110, 7'(3 + R), 2'b00},  // R7 recovered
    {3'b001, 7'd3,      2'b11},  // R5 switch loss during access
    {3'b110, 7'd3,      2'b10},  // R6 battery off, still protected
    {3'b110, 7'(R),     2'b00}   // R7 recovered from backup
  };

  function automatic string vecReq(int i);
    case (i)
      0: return "R10"; 1: return "R2"; 2: return "R5"; 3: return "R9";
      4: return "R6";  5: return "R7"; 6: return "R7"; 7: return "R3";
      8: return "R4";  9: return "R7"; 10: return "R5"; 11: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic expP, logic expB);
    checks++;
    if (protect !== expP || batterySel !== expB) begin
      fails++;
      $display("FAIL %s: protect=%b batterySel=%b expected protect=%b batterySel=%b",
               req, protect, batterySel, expP, expB);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    tick(2);
    check("R1", 1'b1, 1'b0);             // reset values
    rstN = 1'b1;
    tick(2 + R);
    check("R1", 1'b1, 1'b0);             // still held after reset
    tick(1);
    check("R1", 1'b0, 1'b0);             // released at 3+R

    for (int i = 0; i < NVEC; i++) begin
      supRaw = VEC[i][11];
      swRaw  = VEC[i][10];
      acc    = VEC[i][9];
      tick(int'(VEC[i][8:2]));
      check(vecReq(i), VEC[i][1], VEC[i][0]);
    end

    // R3 grace timeout with access held high
    acc = 1'b1; supRaw = 1'b0;
    tick(2 + G);
    check("R3", 1'b0, 1'b0);
    tick(1);
    check("R3", 1'b1, 1'b0);
    acc = 1'b0;
    tick(2);
    check("R10", 1'b1, 1'b0);
    supRaw = 1'b1;
    tick(3 + R);
    check("R7", 1'b0, 1'b0);

    // R8 dip during recovery restarts the timer
    supRaw = 1'b0;
    tick(3);
    check("R2", 1'b1, 1'b0);
    supRaw = 1'b1;
    tick(8);
    supRaw = 1'b0;
    tick(3);
    check("R8", 1'b1, 1'b0);
    supRaw = 1'b1;
    tick(2 + R);
    check("R8", 1'b1, 1'b0);
    tick(1);
    check("R8", 1'b0, 1'b0);

    // R1 reset during operation forces protection at once
    rstN = 1'b0;
    #1;
    check("R1", 1'b1, 1'b0);
    tick(1);
    finish_run();
  end

endmodule